// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the serial bit timing of a UART from the system clock with a numerically controlled oscillator. A 16-bit increment, taken from the upper half of the UART control word, is added to a 16-bit phase accumulator on every clock. Each carry out of the accumulator is an oversample tick at sixteen times the bit rate, so the bit rate is increment × f_clk / 2^20. Because the increment is fractional, the bit rate can be set in fine steps instead of being limited to integer divisions of the clock.

A divide-by-16 stage turns the oversample ticks into a one-cycle bit strobe. A divide-by-10 stage turns bit strobes into a character strobe that marks one start bit, eight data bits and one stop bit. The two low bits of the control word enable the transmit and receive directions. While neither is set, all state sits at zero and no strobe is produced. Each direction also gets its own gated copy of the bit strobe.

Top module: `baud_nco_gen`

## Requirements
- R1: During reset and on the first cycles after reset, every output is low. Reset is synchronous and active low.
- R2: The increment is ctrl_word[31:16]. After the generator starts from zero phase, the number of cycles with os_tick_o high among the first K cycles is floor(K × increment / 65536).
- R3: bit_stb_o goes high for one cycle, in the cycle after every 16th oversample tick.
- R4: char_stb_o goes high for one cycle, in the cycle after every 10th bit strobe.
- R5: ctrl_word[0] is transmit enable and ctrl_word[1] is receive enable. When both are low, all outputs are low from the next cycle on and the phase and counters return to zero. Enabling again restarts from zero phase.
- R6: A new increment takes effect on the next clock edge and does not clear the accumulated phase.
- R7: tx_bit_stb_o repeats bit_stb_o only while ctrl_word[0] is set, and rx_bit_stb_o repeats it only while ctrl_word[1] is set.
- R8: With a zero increment, no oversample tick is produced even while enabled.
- R9: The bit strobe never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 32 | Control word: [31:16] increment, [1] receive enable, [0] transmit enable |
| os_tick_o | output | 1 | Oversample tick, 16 per bit |
| bit_stb_o | output | 1 | One-cycle strobe per bit time |
| char_stb_o | output | 1 | One-cycle strobe per 10 bit times |
| tx_bit_stb_o | output | 1 | Bit strobe gated by transmit enable |
| rx_bit_stb_o | output | 1 | Bit strobe gated by receive enable |

## Verification
A wrong accumulator value shows at os_tick_o within a few cycles for large increments. For small increments it may take up to 65536/increment cycles, as a tick that comes early or late against the floor formula. A fault in the divide-by-16 counter shows within 16 ticks as a misplaced or missing bit strobe. A fault in the divide-by-10 counter needs up to ten bit times before the character strobe moves. Accumulated phase that survives a disable, or an increment change that clears the phase, moves the next tick by one or more cycles, and the bench measures this directly.

// File: rtl/baud_nco_pkg.sv
// Package: field positions of the UART control word used by the baud generator.
// Assumes a 32-bit control word, with the increment in the upper half.
package baud_nco_pkg;
    localparam int CTRL_W       = 32;
    localparam int CTRL_TX_BIT  = 0;
    localparam int CTRL_RX_BIT  = 1;
    localparam int INC_LSB      = 16;
    localparam int INC_W        = 16;
    localparam int INC_MSB      = INC_LSB + INC_W - 1;

    // Extract the phase increment from a control word.
    function automatic logic [INC_W-1:0] ctrl_inc(input logic [CTRL_W-1:0] c);
        return c[INC_MSB:INC_LSB];
    endfunction
endpackage

// File: rtl/nco_phase_acc.sv
// Module: phase accumulator. Adds the increment every enabled cycle and emits
// a registered tick whenever the sum carries out of the accumulator width.
// Assumes run drops to clear: phase returns to zero while run is low.
module nco_phase_acc #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ACC_W-1:0] inc,
    output logic             tick_o
);
    logic [ACC_W-1:0] phase_q;
    logic [ACC_W:0]   sum;

    // Next phase with the carry in the top bit.
    always_comb begin
        sum = {1'b0, phase_q} + {1'b0, inc};
    end

    // Phase register and carry-derived tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
            tick_o  <= 1'b0;
        end else begin
            phase_q <= sum[ACC_W-1:0];
            tick_o  <= sum[ACC_W];
        end
    end
endmodule

// File: rtl/strobe_divider.sv
// Module: divides a one-cycle step pulse by MODULUS and emits a registered
// one-cycle strobe in the cycle after every MODULUS-th step.
// Assumes step is a single-cycle pulse; run low clears the count.
module strobe_divider #(
    parameter int MODULUS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic step,
    output logic stb_o
);
    localparam int CNT_W = (MODULUS > 1) ? $clog2(MODULUS) : 1;
    localparam bit POW2  = (MODULUS > 1) && ((MODULUS & (MODULUS - 1)) == 0);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             at_last;

    // Terminal count detection.
    assign at_last = (cnt_q == CNT_W'(MODULUS - 1));

    generate
        if (POW2) begin : g_wrap
            // Power-of-two modulus: count wraps by itself.
            always_comb begin
                cnt_next = cnt_q + 1'b1;
            end
        end else begin : g_cmp
            // Other moduli: return to zero at the terminal count.
            always_comb begin
                cnt_next = at_last ? '0 : cnt_q + 1'b1;
            end
        end
    endgenerate

    // Count steps and register the terminal strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            stb_o <= 1'b0;
        end else begin
            stb_o <= step && at_last;
            if (step) begin
                cnt_q <= cnt_next;
            end
        end
    end
endmodule

// File: rtl/baud_nco_gen.sv
// Module: fractional baud tick generator. Phase accumulator gives the
// oversample tick; two dividers give bit and character strobes.
// Assumes ctrl_word is synchronous to clk; either enable bit runs the chain.
module baud_nco_gen
    import baud_nco_pkg::*;
#(
    parameter int OVERSAMPLE    = 16,
    parameter int BITS_PER_CHAR = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              os_tick_o,
    output logic              bit_stb_o,
    output logic              char_stb_o,
    output logic              tx_bit_stb_o,
    output logic              rx_bit_stb_o
);
    logic             tx_en;
    logic             rx_en;
    logic             run;
    logic [INC_W-1:0] inc;

    // Decode the control word.
    always_comb begin
        tx_en = ctrl_word[CTRL_TX_BIT];
        rx_en = ctrl_word[CTRL_RX_BIT];
        run   = tx_en | rx_en;
        inc   = ctrl_inc(ctrl_word);
    end

    nco_phase_acc #(.ACC_W(INC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .inc    (inc),
        .tick_o (os_tick_o)
    );

    strobe_divider #(.MODULUS(OVERSAMPLE)) u_bitdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .step  (os_tick_o),
        .stb_o (bit_stb_o)
    );

    strobe_divider #(.MODULUS(BITS_PER_CHAR)) u_chardiv (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .step  (bit_stb_o),
        .stb_o (char_stb_o)
    );

    // Per-direction copies of the bit strobe.
    always_comb begin
        tx_bit_stb_o = bit_stb_o & tx_en;
        rx_bit_stb_o = bit_stb_o & rx_en;
    end
endmodule

// File: rtl/baud_nco_chk.sv
// Module: assertion checker for baud_nco_gen, attached by bind.
module baud_nco_chk
    import baud_nco_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              os_tick_o,
    input logic              bit_stb_o,
    input logic              char_stb_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_word[CTRL_TX_BIT] || ctrl_word[CTRL_RX_BIT]) |=> (!os_tick_o && !bit_stb_o && !char_stb_o)); // R5

    AST_BIT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |-> $past(os_tick_o)); // R3

    AST_CHAR_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        char_stb_o |-> $past(bit_stb_o)); // R4

    AST_BIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |=> !bit_stb_o); // R9

    AST_ZERO_INC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_inc(ctrl_word) == '0) |=> !os_tick_o); // R8
endmodule

bind baud_nco_gen baud_nco_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_word  (ctrl_word),
    .os_tick_o  (os_tick_o),
    .bit_stb_o  (bit_stb_o),
    .char_stb_o (char_stb_o)
);

// File: tb/tb_baud_nco_gen.sv
module tb_baud_nco_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = 32'h0;
    logic        os_tick_o, bit_stb_o, char_stb_o, tx_bit_stb_o, rx_bit_stb_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    baud_nco_gen dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_word    (ctrl_word),
        .os_tick_o    (os_tick_o),
        .bit_stb_o    (bit_stb_o),
        .char_stb_o   (char_stb_o),
        .tx_bit_stb_o (tx_bit_stb_o),
        .rx_bit_stb_o (rx_bit_stb_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ticks_in(input longint k, input longint inc);
        if (k <= 0) return 0;
        return (k * inc) >> 16;
    endfunction

    function automatic logic [31:0] mk(input logic [15:0] inc, input logic [1:0] en);
        return {inc, 14'b0, en};
    endfunction

    // Stop the chain for one cycle so it restarts from zero phase.
    task automatic restart(input logic [15:0] inc, input logic [1:0] en);
        @(negedge clk);
        ctrl_word = mk(inc, 2'b00);
        @(negedge clk);
        ctrl_word = mk(inc, en);
    endtask

    // R1: outputs low in and just after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        ctrl_word = mk(16'hFFFF, 2'b11);
        repeat (4) @(negedge clk);
        check(!(os_tick_o | bit_stb_o | char_stb_o | tx_bit_stb_o | rx_bit_stb_o),
              "R1 in reset", {os_tick_o, bit_stb_o, char_stb_o}, 0);
        ctrl_word = 32'h0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!(os_tick_o | bit_stb_o | char_stb_o), "R1 after reset",
              {os_tick_o, bit_stb_o, char_stb_o}, 0);
    endtask

    // R2 R3 R4 R7 R9: count strobes over a window against the rate formula.
    task automatic t_window(input logic [15:0] inc, input logic [1:0] en, input int k);
        longint nt = 0, nb = 0, nc = 0, ntx = 0, nrx = 0, dbl = 0;
        longint et, eb, ec;
        logic prev_b = 1'b0;
        restart(inc, en);
        for (int i = 1; i <= k; i++) begin
            @(negedge clk);
            nt += os_tick_o; nb += bit_stb_o; nc += char_stb_o;
            ntx += tx_bit_stb_o; nrx += rx_bit_stb_o;
            if (prev_b && bit_stb_o) dbl++;
            prev_b = bit_stb_o;
        end
        et = ticks_in(k, inc);
        eb = ticks_in(k - 1, inc) / 16;
        ec = (ticks_in(k - 2, inc) / 16) / 10;
        check(nt == et, "R2 tick count", nt, et);
        check(nb == eb, "R3 bit strobe count", nb, eb);
        check(nc == ec, "R4 char strobe count", nc, ec);
        check(ntx == (en[0] ? eb : 0), "R7 tx strobe count", ntx, en[0] ? eb : 0);
        check(nrx == (en[1] ? eb : 0), "R7 rx strobe count", nrx, en[1] ? eb : 0);
        check(dbl == 0, "R9 double bit strobe", dbl, 0);
    endtask

    // R5: disable clears outputs and phase.
    task automatic t_disable();
        longint nt = 0;
        restart(16'hFFFF, 2'b11);
        repeat (40) @(negedge clk);
        ctrl_word = mk(16'hFFFF, 2'b00);
        @(negedge clk);
        check(!(os_tick_o | bit_stb_o | char_stb_o), "R5 quiet after disable",
              {os_tick_o, bit_stb_o, char_stb_o}, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            nt += os_tick_o + bit_stb_o + char_stb_o;
        end
        check(nt == 0, "R5 stays quiet", nt, 0);
        ctrl_word = mk(16'h8000, 2'b01);
        @(negedge clk);
        check(os_tick_o == 1'b0, "R5 zero phase sample1", os_tick_o, 0);
        @(negedge clk);
        check(os_tick_o == 1'b1, "R5 zero phase sample2", os_tick_o, 1);
    endtask

    // R6: increment change applies next edge and keeps the phase.
    task automatic t_inc_change();
        restart(16'h8000, 2'b10);
        @(negedge clk);
        @(negedge clk);
        check(os_tick_o == 1'b1, "R6 first tick", os_tick_o, 1);
        @(negedge clk);
        ctrl_word = mk(16'h4000, 2'b10);
        @(negedge clk);
        check(os_tick_o == 1'b0, "R6 no tick at 0xC000", os_tick_o, 0);
        @(negedge clk);
        check(os_tick_o == 1'b1, "R6 tick from kept phase", os_tick_o, 1);
    endtask

    // R8: zero increment gives no ticks.
    task automatic t_zero_inc();
        longint nt = 0;
        restart(16'h0000, 2'b11);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            nt += os_tick_o;
        end
        check(nt == 0, "R8 zero increment ticks", nt, 0);
    endtask

    initial begin
        t_reset();
        t_window(16'h1000, 2'b11, 3000);
        t_window(16'h8000, 2'b01, 1000);
        t_window(16'h2AAB, 2'b10, 2000);
        t_window(16'hFFFF, 2'b11, 700);
        t_disable();
        t_inc_change();
        t_zero_inc();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule